// File: doc/BRIEF.md
# Complex Product Scaler and Output Selector

This block sits after a complex multiplier. Each cycle it takes a full-width complex product (real and imaginary words), applies a programmable power-of-two scale and registers the result. A 2-bit output selector then routes parts of the registered product onto two half-width output ports without any further register stage. The selector can show the upper halves of both parts, the lower halves of both parts, or one whole part split across the two ports.

The block has two modes. In normal mode a 2-bit scale code moves the product one place left, leaves it alone, or moves it one or two places right. Right shifts are arithmetic. A registered flag reports when the left shift drops a significant bit. In block floating point mode the product passes unscaled and a second 2-bit code shifts an auxiliary complex A-word right by one to four places, so that its weighting matches the product before a later accumulation stage. In block floating point mode the select bits are expected to be held low.

Top module: `cplx_scale_sel`

## Requirements
- R1: In normal mode (`bfp_mode`=0), scale code 00 registers the product unchanged; all registered results appear one clock edge after the inputs are sampled.
- R2: In normal mode, scale code 11 shifts each part one place left, with a zero entering at bit 0 and the top bit discarded.
- R3: In normal mode, scale code 01 shifts each part one place right arithmetically. The sign bit is copied into the top bit and bit 0 is discarded.
- R4: In normal mode, scale code 10 shifts each part two places right arithmetically, with sign extension.
- R5: `ovf_flag` goes high in the same cycle as the scaled product when normal mode and scale code 11 were applied and the two most significant bits of the real part or of the imaginary part differ.
- R6: `ovf_flag` stays low for every other scale code and for all block floating point inputs.
- R7: In block floating point mode (`bfp_mode`=1), the product is registered unscaled whatever the scale code.
- R8: In block floating point mode, A-word code 00, 01, 10 or 11 shifts both A-word parts right arithmetically by 1, 2, 3 or 4 places, and the result is registered.
- R9: In normal mode, the A-word is registered unshifted and its code has no effect.
- R10: Select 00 drives `port_p` with the upper half of the real part and `port_q` with the upper half of the imaginary part.
- R11: Select 01 drives `port_p` and `port_q` with the lower halves of the real and imaginary parts.
- R12: Select 10 drives the whole real part and select 11 the whole imaginary part, with the upper half on `port_p` and the lower half on `port_q`.
- R13: The selector is combinational: a change of `osel` alters the ports within the same cycle, with no clock edge needed.
- R14: While `rst_n` is low, all registered outputs and the flag are zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bfp_mode | input | 1 | 1 = block floating point mode, 0 = normal mode |
| scale_sel | input | 2 | Normal-mode product scale code |
| prod_re | input | PW | Real part of the complex product |
| prod_im | input | PW | Imaginary part of the complex product |
| aw_code | input | 2 | A-word right-shift code (block floating point mode) |
| aword_re | input | AW | Real part of the A-word |
| aword_im | input | AW | Imaginary part of the A-word |
| osel | input | 2 | Output select, applied combinationally |
| port_p | output | PW/2 | First output port |
| port_q | output | PW/2 | Second output port |
| ovf_flag | output | 1 | Left-shift overflow flag, registered |
| aword_re_o | output | AW | Shifted real A-word, registered |
| aword_im_o | output | AW | Shifted imaginary A-word, registered |

## Verification
The bench builds the block with its defaults: a 32-bit product and a 16-bit A-word. These widths make the exact boundary words reachable: 0x4000_0000 and 0x8000_0001 overflow on the left shift, while 0xC000_0000 does not. They also make a four-place shift of a 16-bit negative A-word visible bit by bit. Because the ports are half the product width, every select setting exposes different bits of the same registered word, and the bench uses this to check each half separately, including an `osel` sweep within one clock period.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
   typedef enum logic [1:0] {
      SC_NONE = 2'b00,
      SC_R1   = 2'b01,
      SC_R2   = 2'b10,
      SC_L1   = 2'b11
   } scale_e;

   typedef enum logic [1:0] {
      OS_HI = 2'b00,
      OS_LO = 2'b01,
      OS_RE = 2'b10,
      OS_IM = 2'b11
   } osel_e;
endpackage

// File: rtl/cps_lane_scaler.sv
`timescale 1ns/1ps
module cps_lane_scaler
   import cps_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bfp,
   input  logic [1:0]   code,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         ovf
);
   logic [W-1:0] nxt;
   logic         ovf_nxt;

   always_comb begin
      nxt     = din;
      ovf_nxt = 1'b0;
      if (!bfp) begin
         case (scale_e'(code))
            SC_L1: begin
               nxt     = {din[W-2:0], 1'b0};
               ovf_nxt = din[W-1] ^ din[W-2];
            end
            SC_R1:   nxt = {din[W-1], din[W-1:1]};
            SC_R2:   nxt = {{2{din[W-1]}}, din[W-1:2]};
            default: nxt = din;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         ovf  <= 1'b0;
      end else begin
         dout <= nxt;
         ovf  <= ovf_nxt;
      end
   end
endmodule

// File: rtl/cps_aword_shifter.sv
`timescale 1ns/1ps
module cps_aword_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bfp,
   input  logic [1:0]   code,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = din;
      if (bfp) begin
         case (code)
            2'b00:   nxt = {din[W-1], din[W-1:1]};
            2'b01:   nxt = {{2{din[W-1]}}, din[W-1:2]};
            2'b10:   nxt = {{3{din[W-1]}}, din[W-1:3]};
            default: nxt = {{4{din[W-1]}}, din[W-1:4]};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= '0;
      else        dout <= nxt;
   end
endmodule

// File: rtl/cps_out_sel.sv
`timescale 1ns/1ps
module cps_out_sel
   import cps_pkg::*;
#(
   parameter int PW = 32
) (
   input  logic [1:0]      osel,
   input  logic [PW-1:0]   re,
   input  logic [PW-1:0]   im,
   output logic [PW/2-1:0] port_p,
   output logic [PW/2-1:0] port_q
);
   localparam int HW = PW / 2;

   always_comb begin
      case (osel_e'(osel))
         OS_HI: begin
            port_p = re[PW-1:HW];
            port_q = im[PW-1:HW];
         end
         OS_LO: begin
            port_p = re[HW-1:0];
            port_q = im[HW-1:0];
         end
         OS_RE: begin
            port_p = re[PW-1:HW];
            port_q = re[HW-1:0];
         end
         default: begin
            port_p = im[PW-1:HW];
            port_q = im[HW-1:0];
         end
      endcase
   end
endmodule

// File: rtl/cplx_scale_sel.sv
`timescale 1ns/1ps
module cplx_scale_sel
   import cps_pkg::*;
#(
   parameter int PW = 32,
   parameter int AW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bfp_mode,
   input  logic [1:0]      scale_sel,
   input  logic [PW-1:0]   prod_re,
   input  logic [PW-1:0]   prod_im,
   input  logic [1:0]      aw_code,
   input  logic [AW-1:0]   aword_re,
   input  logic [AW-1:0]   aword_im,
   input  logic [1:0]      osel,
   output logic [PW/2-1:0] port_p,
   output logic [PW/2-1:0] port_q,
   output logic            ovf_flag,
   output logic [AW-1:0]   aword_re_o,
   output logic [AW-1:0]   aword_im_o
);
   localparam int NLANE = 2;

   if (PW < 4 || (PW % 2) != 0) begin : g_bad_pw
      $error("cplx_scale_sel: PW must be even and at least 4");
   end
   if (AW < 5) begin : g_bad_aw
      $error("cplx_scale_sel: AW must be at least 5");
   end

   logic [PW-1:0] lane_in  [NLANE];
   logic [PW-1:0] lane_out [NLANE];
   logic [AW-1:0] a_in     [NLANE];
   logic [AW-1:0] a_out    [NLANE];
   logic [NLANE-1:0] lane_ovf;
   logic [PW-1:0] scaled_re;
   logic [PW-1:0] scaled_im;

   assign lane_in[0] = prod_re;
   assign lane_in[1] = prod_im;
   assign a_in[0]    = aword_re;
   assign a_in[1]    = aword_im;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      cps_lane_scaler #(.W(PW)) u_scale (
         .clk  (clk),
         .rst_n(rst_n),
         .bfp  (bfp_mode),
         .code (scale_sel),
         .din  (lane_in[g]),
         .dout (lane_out[g]),
         .ovf  (lane_ovf[g])
      );
      cps_aword_shifter #(.W(AW)) u_ashift (
         .clk  (clk),
         .rst_n(rst_n),
         .bfp  (bfp_mode),
         .code (aw_code),
         .din  (a_in[g]),
         .dout (a_out[g])
      );
   end

   assign scaled_re  = lane_out[0];
   assign scaled_im  = lane_out[1];
   assign ovf_flag   = |lane_ovf;
   assign aword_re_o = a_out[0];
   assign aword_im_o = a_out[1];

   cps_out_sel #(.PW(PW)) u_sel (
      .osel  (osel),
      .re    (scaled_re),
      .im    (scaled_im),
      .port_p(port_p),
      .port_q(port_q)
   );
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker #(
   parameter int PW = 32,
   parameter int AW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bfp_mode,
   input logic [1:0]      scale_sel,
   input logic [PW-1:0]   prod_re,
   input logic [PW-1:0]   prod_im,
   input logic [1:0]      aw_code,
   input logic [AW-1:0]   aword_re,
   input logic [1:0]      osel,
   input logic [PW/2-1:0] port_p,
   input logic [PW/2-1:0] port_q,
   input logic            ovf_flag,
   input logic [AW-1:0]   aword_re_o,
   input logic [PW-1:0]   scaled_re,
   input logic [PW-1:0]   scaled_im
);
   localparam int HW = PW / 2;

   AST_PASS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bfp_mode && scale_sel == 2'b00) |=> scaled_re == $past(prod_re)); // R1
   AST_LEFT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bfp_mode && scale_sel == 2'b11) |=> scaled_re == {$past(prod_re[PW-2:0]), 1'b0}); // R2
   AST_RIGHT1_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bfp_mode && scale_sel == 2'b01) |=> scaled_re[PW-1:PW-2] == {2{$past(prod_re[PW-1])}}); // R3
   AST_RIGHT2_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bfp_mode && scale_sel == 2'b10) |=> scaled_re[PW-1:PW-3] == {3{$past(prod_re[PW-1])}}); // R4
   AST_OVF_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bfp_mode && scale_sel == 2'b11 && (prod_re[PW-1] != prod_re[PW-2])) |=> ovf_flag); // R5
   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |-> $past(!bfp_mode && scale_sel == 2'b11)); // R6
   AST_BFP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      bfp_mode |=> (scaled_re == $past(prod_re) && scaled_im == $past(prod_im))); // R7
   AST_AWORD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (bfp_mode && aw_code == 2'b11) |=> aword_re_o == {{4{$past(aword_re[AW-1])}}, $past(aword_re[AW-1:4])}); // R8
   AST_AWORD_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !bfp_mode |=> aword_re_o == $past(aword_re)); // R9

   always_comb begin
      if (rst_n === 1'b1) begin
         if (osel == 2'b00)
            AST_SEL_HI: assert (port_p == scaled_re[PW-1:HW] && port_q == scaled_im[PW-1:HW]); // R10
         if (osel == 2'b01)
            AST_SEL_LO: assert (port_p == scaled_re[HW-1:0] && port_q == scaled_im[HW-1:0]); // R11
         if (osel == 2'b10)
            AST_SEL_RE: assert ({port_p, port_q} == scaled_re); // R12
         if (osel == 2'b11)
            AST_SEL_IM: assert ({port_p, port_q} == scaled_im); // R12
      end
   end
endmodule

bind cplx_scale_sel cps_checker #(.PW(PW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bfp_mode  (bfp_mode),
   .scale_sel (scale_sel),
   .prod_re   (prod_re),
   .prod_im   (prod_im),
   .aw_code   (aw_code),
   .aword_re  (aword_re),
   .osel      (osel),
   .port_p    (port_p),
   .port_q    (port_q),
   .ovf_flag  (ovf_flag),
   .aword_re_o(aword_re_o),
   .scaled_re (scaled_re),
   .scaled_im (scaled_im)
);

// File: tb/sim_cplx_scale_sel.sv
`timescale 1ns/1ps
module sim_cplx_scale_sel;
   localparam int PW = 32;
   localparam int AW = 16;
   localparam int HW = PW / 2;

   typedef struct {
      logic [PW-1:0] re;
      logic [PW-1:0] im;
      logic          ovf;
      logic [AW-1:0] are;
      logic [AW-1:0] aim;
      logic [1:0]    os;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bfp_mode = 1'b0;
   logic [1:0]    scale_sel = 2'b00;
   logic [PW-1:0] prod_re = '0;
   logic [PW-1:0] prod_im = '0;
   logic [1:0]    aw_code = 2'b00;
   logic [AW-1:0] aword_re = '0;
   logic [AW-1:0] aword_im = '0;
   logic [1:0]    osel = 2'b00;
   logic [HW-1:0] port_p;
   logic [HW-1:0] port_q;
   logic          ovf_flag;
   logic [AW-1:0] aword_re_o;
   logic [AW-1:0] aword_im_o;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   cplx_scale_sel #(.PW(PW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bfp_mode(bfp_mode), .scale_sel(scale_sel),
      .prod_re(prod_re), .prod_im(prod_im), .aw_code(aw_code),
      .aword_re(aword_re), .aword_im(aword_im), .osel(osel),
      .port_p(port_p), .port_q(port_q), .ovf_flag(ovf_flag),
      .aword_re_o(aword_re_o), .aword_im_o(aword_im_o)
   );

   function automatic logic [PW-1:0] m_scale(input logic b, input logic [1:0] c, input logic [PW-1:0] v);
      logic signed [PW-1:0] s;
      s = v;
      if (b) return v;
      case (c)
         2'b00:   return v;
         2'b01:   return s >>> 1;
         2'b10:   return s >>> 2;
         default: return v << 1;
      endcase
   endfunction

   function automatic logic m_ovf(input logic b, input logic [1:0] c, input logic [PW-1:0] r, input logic [PW-1:0] i);
      return !b && c == 2'b11 && ((r[PW-1] != r[PW-2]) || (i[PW-1] != i[PW-2]));
   endfunction

   function automatic logic [AW-1:0] m_ash(input logic b, input logic [1:0] c, input logic [AW-1:0] v);
      logic signed [AW-1:0] s;
      s = v;
      if (!b) return v;
      return s >>> (int'(c) + 1);
   endfunction

   function automatic logic [PW-1:0] m_sel(input logic [1:0] o, input logic [PW-1:0] r, input logic [PW-1:0] i);
      case (o)
         2'b00:   return {r[PW-1:HW], i[PW-1:HW]};
         2'b01:   return {r[HW-1:0], i[HW-1:0]};
         2'b10:   return r;
         default: return i;
      endcase
   endfunction

   task automatic drive(input logic b, input logic [1:0] sc, input logic [PW-1:0] r,
                        input logic [PW-1:0] i, input logic [1:0] ac, input logic [AW-1:0] ar,
                        input logic [AW-1:0] ai, input logic [1:0] os, input string tag);
      exp_t e;
      @(negedge clk);
      bfp_mode = b; scale_sel = sc; prod_re = r; prod_im = i;
      aw_code = ac; aword_re = ar; aword_im = ai; osel = os;
      e.re  = m_scale(b, sc, r);
      e.im  = m_scale(b, sc, i);
      e.ovf = m_ovf(b, sc, r, i);
      e.are = m_ash(b, ac, ar);
      e.aim = m_ash(b, ac, ai);
      e.os  = os;
      e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            logic [PW-1:0] want;
            e = sb.pop_front();
            want = m_sel(e.os, e.re, e.im);
            n_chk++;
            if ({port_p, port_q} != want || ovf_flag != e.ovf ||
                aword_re_o != e.are || aword_im_o != e.aim) begin
               n_bad++;
               $display("FAIL %s: actual p/q=%h ovf=%b a=%h/%h expected p/q=%h ovf=%b a=%h/%h",
                        e.tag, {port_p, port_q}, ovf_flag, aword_re_o, aword_im_o,
                        want, e.ovf, e.are, e.aim);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      // R14: reset holds outputs at zero despite live inputs
      prod_re = 32'h7FFF_0001; prod_im = 32'h8000_0003; scale_sel = 2'b11;
      aword_re = 16'h1234; aword_im = 16'h8765;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if ({port_p, port_q} != '0 || ovf_flag !== 1'b0 || aword_re_o != '0 || aword_im_o != '0) begin
         n_bad++;
         $display("FAIL R14: actual p/q=%h ovf=%b a=%h/%h expected all zero",
                  {port_p, port_q}, ovf_flag, aword_re_o, aword_im_o);
      end
      rst_n = 1'b1;

      // R1 R10 R11 R12: unscaled, each select
      drive(0, 2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 2'b10, 16'hF00D, 16'h0BAD, 2'b00, "R1 R10 none/upper");
      drive(0, 2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 16'h1111, 16'h2222, 2'b01, "R11 none/lower");
      drive(0, 2'b00, 32'hA5A5_0F0F, 32'h5A5A_F0F0, 2'b01, 16'h3333, 16'h4444, 2'b10, "R12 real word");
      drive(0, 2'b00, 32'hA5A5_0F0F, 32'h5A5A_F0F0, 2'b11, 16'h5555, 16'h6666, 2'b11, "R12 imag word");
      // R2 R5 R6: left shift, with and without overflow
      drive(0, 2'b11, 32'h2000_0001, 32'hE000_0003, 2'b11, 16'h8000, 16'h7FFF, 2'b10, "R2 R6 left no ovf");
      drive(0, 2'b11, 32'h4000_0000, 32'h0000_0001, 2'b00, 16'h0, 16'h0, 2'b10, "R2 R5 ovf real 01");
      drive(0, 2'b11, 32'h0000_0001, 32'h8000_0001, 2'b00, 16'h0, 16'h0, 2'b11, "R5 ovf imag 10");
      drive(0, 2'b11, 32'hC000_0000, 32'h3FFF_FFFF, 2'b00, 16'h0, 16'h0, 2'b01, "R6 top bits equal");
      // R3 R4: arithmetic right shifts
      drive(0, 2'b01, 32'h8000_0001, 32'h7FFF_FFFF, 2'b00, 16'h0, 16'h0, 2'b10, "R3 right1 neg real");
      drive(0, 2'b01, 32'h8000_0001, 32'h7FFF_FFFF, 2'b00, 16'h0, 16'h0, 2'b11, "R3 right1 pos imag");
      drive(0, 2'b10, 32'h8000_0000, 32'h4000_0007, 2'b00, 16'h0, 16'h0, 2'b10, "R4 right2 neg");
      drive(0, 2'b10, 32'h8000_0000, 32'h4000_0007, 2'b00, 16'h0, 16'h0, 2'b11, "R4 right2 pos");
      drive(0, 2'b10, 32'h4000_4000, 32'hFFFF_FFFF, 2'b00, 16'h0, 16'h0, 2'b01, "R4 ovf low");
      // R7 R8 R6: block floating point
      drive(1, 2'b11, 32'h4000_0000, 32'h8000_0001, 2'b00, 16'h8001, 16'h7FFE, 2'b00, "R7 R8 R6 bfp a1");
      drive(1, 2'b01, 32'h1357_9BDF, 32'hFEDC_BA98, 2'b01, 16'h8001, 16'h7FFE, 2'b00, "R8 bfp a2");
      drive(1, 2'b10, 32'hFFFF_0000, 32'h0000_FFFF, 2'b10, 16'h8001, 16'h7FFE, 2'b00, "R8 bfp a3");
      drive(1, 2'b00, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 2'b11, 16'h8001, 16'h7FFE, 2'b00, "R8 bfp a4");
      // R9: A-word code ignored in normal mode
      drive(0, 2'b00, 32'h0, 32'h0, 2'b11, 16'hC3A5, 16'h5A3C, 2'b00, "R9 normal a-word");

      // R13: osel sweep within one cycle
      drive(0, 2'b01, 32'h8642_1357, 32'h2468_ACE0, 2'b00, 16'h0, 16'h0, 2'b00, "R13 setup");
      @(posedge clk);
      #1.2;
      for (int k = 0; k < 4; k++) begin
         logic [PW-1:0] want;
         osel = 2'(k);
         #0.2;
         want = m_sel(2'(k), m_scale(0, 2'b01, 32'h8642_1357), m_scale(0, 2'b01, 32'h2468_ACE0));
         n_chk++;
         if ({port_p, port_q} != want) begin
            n_bad++;
            $display("FAIL R13 osel=%0d: actual %h expected %h", k, {port_p, port_q}, want);
         end
      end

      // mixed patterns across all requirements R1..R12
      for (int n = 0; n < 300; n++) begin
         logic b;
         b = ($urandom % 4) == 0;
         drive(b, 2'($urandom), $urandom, $urandom, 2'($urandom), 16'($urandom), 16'($urandom),
               b ? 2'b00 : 2'($urandom), "R1-mix random");
      end

      repeat (3) @(posedge clk);
      #2;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule